// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits between a CPU bus and a small on-chip flash array. It watches write cycles for fixed unlock-and-command sequences and starts one of two operations when a sequence completes. A full-array erase needs six exact writes. A single-byte program needs four, and the last of those four carries the target address and the data byte. A separate control-register write port arms or disarms command execution. When command execution is disarmed, sequence writes are ignored.

The array is a behavioural model. A busy timer holds it busy for a parameterised number of clock cycles after each operation. While it is busy, every read returns a status byte whose bit 6 flips on each read strobe. Software therefore detects completion by reading until two consecutive reads agree. The array occupies the address window whose top four bits are F. Cells are selected by the low `ARRAY_AW` address bits, so the array repeats (aliases) across that window.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Command execution is disarmed after reset. A control write of 38h arms it, a control write of C8h disarms it, and any other control value leaves the armed state unchanged.
- R2: While armed and idle, the writes AAh@F555h, 55h@FAAAh, 80h@F555h, AAh@F555h, 55h@FAAAh, 10h@F555h, in that order, erase every cell to FFh.
- R3: While armed and idle, the writes AAh@F555h, 55h@FAAAh, A0h@F555h, followed by a write of D to address A in the array window, change the cell at A to (old value AND D).
- R4: A write that does not match the next expected address and data returns the sequencer to idle without changing the array. A new sequence must then begin again from its first write.
- R5: While an operation is busy, a read returns a status byte with bits other than bit 6 equal to zero, and bit 6 inverts on every read strobe.
- R6: Writes that arrive while an operation is busy, including complete command sequences, have no effect.
- R7: Busy lasts exactly ERASE_CYC clock cycles after the edge that accepts the final erase write, and PROG_CYC cycles after the final program write. A read strobed on the following edge returns array data.
- R8: While disarmed, command sequences are ignored and the array is unchanged.
- R9: Read data is registered and appears the cycle after the read strobe, and it is 00h after reset. An idle read in the window returns the cell selected by the low ARRAY_AW address bits. An idle read outside the window returns 00h. The array resets to FFh.
- R10: A plain write into the array window that is not the final write of a program sequence does not change the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control-register write strobe |
| ctl_wdata | input | DATA_W | Control-register write value (38h arm, C8h disarm) |
| bus_addr | input | ADDR_W | CPU byte address |
| bus_wdata | input | DATA_W | CPU write data |
| bus_we | input | 1 | CPU write strobe, one cycle per write |
| bus_re | input | 1 | CPU read strobe, one cycle per read |
| bus_rdata | output | DATA_W | Registered read data or busy status |

## Verification
The bench programs one cell twice to show that bits only ever clear. A design that overwrote the cell instead would read back 0F0h rather than 30h. It breaks sequences partway through with a wrong byte, then presents the correct remainder without the restart. A decoder that resynchronised wrongly or stayed mid-sequence would then program a cell that must stay FFh. It counts the busy reads one by one against the two cycle parameters, so an off-by-one timer shows up as data arriving a read early or late. It also replays a full program sequence during an erase, so a design that accepted writes while busy leaves 00h where FFh belongs. Disarm, a non-pattern control value and reset are each followed by a sequence that must not take effect.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_ERS3,
        SQ_ERS4,
        SQ_ERS5,
        SQ_PRG3
    } seq_state_e;

    localparam logic [7:0] CODE_KEY_A     = 8'hAA;
    localparam logic [7:0] CODE_KEY_B     = 8'h55;
    localparam logic [7:0] CODE_ERASE_ARM = 8'h80;
    localparam logic [7:0] CODE_ERASE_ALL = 8'h10;
    localparam logic [7:0] CODE_PROGRAM   = 8'hA0;
    localparam logic [7:0] CTL_ARM        = 8'h38;
    localparam logic [7:0] CTL_DISARM     = 8'hC8;

endpackage

// File: rtl/flcmd_enable.sv
module flcmd_enable
    import flcmd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic              cmd_en
);

    typedef struct packed {
        logic en;
    } en_s;

    en_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            if (ctl_wdata == DATA_W'(CTL_ARM)) begin
                st_d.en = 1'b1;
            end else if (ctl_wdata == DATA_W'(CTL_DISARM)) begin
                st_d.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_en = st_q.en;

    AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata == DATA_W'(CTL_ARM)) |=> cmd_en)
        else $error("arm pattern did not enable commands"); // R1

    AST_OTHER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata != DATA_W'(CTL_ARM) && ctl_wdata != DATA_W'(CTL_DISARM))
        |=> $stable(cmd_en))
        else $error("non-pattern control write changed enable"); // R1

endmodule

// File: rtl/flcmd_seq.sv
module flcmd_seq
    import flcmd_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] UNLK_A1 = 16'hF555,
    parameter logic [ADDR_W-1:0] UNLK_A2 = 16'hFAAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_en,
    input  logic              busy,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              start_erase,
    output logic              start_prog
);

    typedef struct packed {
        seq_state_e state;
    } seq_s;

    seq_s st_d, st_q;

    logic accept;
    logic at_a1;
    logic at_a2;

    assign accept = bus_we && cmd_en && !busy;
    assign at_a1  = (bus_addr == UNLK_A1);
    assign at_a2  = (bus_addr == UNLK_A2);

    always_comb begin
        st_d        = st_q;
        start_erase = 1'b0;
        start_prog  = 1'b0;
        if (!cmd_en) begin
            st_d.state = SQ_IDLE;
        end else if (accept) begin
            st_d.state = SQ_IDLE;
            unique case (st_q.state)
                SQ_IDLE: begin
                    if (at_a1 && bus_wdata == DATA_W'(CODE_KEY_A)) st_d.state = SQ_UNL1;
                end
                SQ_UNL1: begin
                    if (at_a2 && bus_wdata == DATA_W'(CODE_KEY_B)) st_d.state = SQ_UNL2;
                end
                SQ_UNL2: begin
                    if (at_a1 && bus_wdata == DATA_W'(CODE_ERASE_ARM)) begin
                        st_d.state = SQ_ERS3;
                    end else if (at_a1 && bus_wdata == DATA_W'(CODE_PROGRAM)) begin
                        st_d.state = SQ_PRG3;
                    end
                end
                SQ_ERS3: begin
                    if (at_a1 && bus_wdata == DATA_W'(CODE_KEY_A)) st_d.state = SQ_ERS4;
                end
                SQ_ERS4: begin
                    if (at_a2 && bus_wdata == DATA_W'(CODE_KEY_B)) st_d.state = SQ_ERS5;
                end
                SQ_ERS5: begin
                    if (at_a1 && bus_wdata == DATA_W'(CODE_ERASE_ALL)) start_erase = 1'b1;
                end
                SQ_PRG3: begin
                    start_prog = 1'b1;
                end
                default: begin
                    st_d.state = SQ_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= SQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    AST_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_en |=> (st_q.state == SQ_IDLE))
        else $error("sequencer left idle while commands disabled"); // R8

endmodule

// File: rtl/flcmd_array.sv
module flcmd_array #(
    parameter int              DATA_W     = 8,
    parameter int              ARRAY_AW   = 6,
    parameter int              WIN_W      = 4,
    parameter logic [WIN_W-1:0] WIN_TAG   = 4'hF,
    parameter int              ERASE_CYC  = 64,
    parameter int              PROG_CYC   = 8,
    parameter int              STATUS_BIT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_re,
    input  logic [WIN_W-1:0]    rd_tag,
    input  logic [ARRAY_AW-1:0] rd_idx,
    input  logic [WIN_W-1:0]    pg_tag,
    input  logic [ARRAY_AW-1:0] pg_idx,
    input  logic [DATA_W-1:0]   pg_data,
    input  logic                start_erase,
    input  logic                start_prog,
    output logic                busy,
    output logic [DATA_W-1:0]   rdata
);

    localparam int DEPTH   = 1 << ARRAY_AW;
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [CNT_W-1:0]             cnt;
        logic                         tog;
        logic [DATA_W-1:0]            rdata;
    } arr_s;

    arr_s st_d, st_q;

    logic              rd_in_win;
    logic              pg_in_win;
    logic [DATA_W-1:0] status_word;

    assign busy      = (st_q.cnt != '0);
    assign rd_in_win = (rd_tag == WIN_TAG);
    assign pg_in_win = (pg_tag == WIN_TAG);

    always_comb begin
        status_word             = '0;
        status_word[STATUS_BIT] = st_q.tog;
    end

    always_comb begin
        st_d = st_q;
        if (busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (start_erase) begin
            st_d.mem = '1;
            st_d.cnt = CNT_W'(ERASE_CYC);
        end else if (start_prog && pg_in_win) begin
            st_d.mem[pg_idx] = st_q.mem[pg_idx] & pg_data;
            st_d.cnt         = CNT_W'(PROG_CYC);
        end

        if (bus_re) begin
            if (busy) begin
                st_d.rdata = status_word;
                st_d.tog   = ~st_q.tog;
            end else if (rd_in_win) begin
                st_d.rdata = st_q.mem[rd_idx];
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mem   <= '1;
            st_q.cnt   <= '0;
            st_q.tog   <= 1'b0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(start_erase || start_prog))
        else $error("operation requested while array busy"); // R6

    AST_ERASE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_erase && !busy) |=> (st_q.mem[0] == '1 && st_q.mem[DEPTH-1] == '1))
        else $error("erase left a programmed cell"); // R2

    AST_STATUS_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && busy) ##1 (bus_re && busy) |=> (rdata[STATUS_BIT] != $past(rdata[STATUS_BIT])))
        else $error("busy status bit did not flip between reads"); // R5

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                ARRAY_AW  = 6,
    parameter int                WIN_W     = 4,
    parameter logic [WIN_W-1:0]  WIN_TAG   = 4'hF,
    parameter int                ERASE_CYC = 64,
    parameter int                PROG_CYC  = 8,
    parameter logic [ADDR_W-1:0] UNLK_A1   = 16'hF555,
    parameter logic [ADDR_W-1:0] UNLK_A2   = 16'hFAAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata
);

    logic cmd_en;
    logic busy;
    logic start_erase;
    logic start_prog;

    flcmd_enable #(
        .DATA_W (DATA_W)
    ) u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .cmd_en    (cmd_en)
    );

    flcmd_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .UNLK_A1 (UNLK_A1),
        .UNLK_A2 (UNLK_A2)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_en      (cmd_en),
        .busy        (busy),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .start_erase (start_erase),
        .start_prog  (start_prog)
    );

    flcmd_array #(
        .DATA_W    (DATA_W),
        .ARRAY_AW  (ARRAY_AW),
        .WIN_W     (WIN_W),
        .WIN_TAG   (WIN_TAG),
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_re      (bus_re),
        .rd_tag      (bus_addr[ADDR_W-1 -: WIN_W]),
        .rd_idx      (bus_addr[ARRAY_AW-1:0]),
        .pg_tag      (bus_addr[ADDR_W-1 -: WIN_W]),
        .pg_idx      (bus_addr[ARRAY_AW-1:0]),
        .pg_data     (bus_wdata),
        .start_erase (start_erase),
        .start_prog  (start_prog),
        .busy        (busy),
        .rdata       (bus_rdata)
    );

endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

    localparam int ERASE_CYC = 64;
    localparam int PROG_CYC  = 8;

    localparam logic [1:0] K_CTL  = 2'd0;
    localparam logic [1:0] K_WR   = 2'd1;
    localparam logic [1:0] K_RD   = 2'd2;
    localparam logic [1:0] K_POLL = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 62;
    localparam vec_t VECS [NV] = '{
        '{K_CTL,  16'h0000, 8'h38, 8'h00, 4'd1},   // R1 arm
        '{K_WR,   16'hF555, 8'hAA, 8'h00, 4'd3},   // R3 program 3F at F000
        '{K_WR,   16'hFAAA, 8'h55, 8'h00, 4'd3},
        '{K_WR,   16'hF555, 8'hA0, 8'h00, 4'd3},
        '{K_WR,   16'hF000, 8'h3F, 8'h00, 4'd3},
        '{K_POLL, 16'hF000, 8'h00, 8'h3F, 4'd3},   // R3
        '{K_WR,   16'hF555, 8'hAA, 8'h00, 4'd3},   // R3 program F0 over 3F
        '{K_WR,   16'hFAAA, 8'h55, 8'h00, 4'd3},
        '{K_WR,   16'hF555, 8'hA0, 8'h00, 4'd3},
        '{K_WR,   16'hF000, 8'hF0, 8'h00, 4'd3},
        '{K_POLL, 16'hF000, 8'h00, 8'h30, 4'd3},   // R3 AND rule
        '{K_WR,   16'hF001, 8'h12, 8'h00, 4'd10},  // R10 plain write
        '{K_RD,   16'hF001, 8'h00, 8'hFF, 4'd10},  // R10
        '{K_WR,   16'hF555, 8'hAA, 8'h00, 4'd2},   // R2 erase
        '{K_WR,   16'hFAAA, 8'h55, 8'h00, 4'd2},
        '{K_WR,   16'hF555, 8'h80, 8'h00, 4'd2},
        '{K_WR,   16'hF555, 8'hAA, 8'h00, 4'd2},
        '{K_WR,   16'hFAAA, 8'h55, 8'h00, 4'd2},
        '{K_WR,   16'hF555, 8'h10, 8'h00, 4'd2},
        '{K_POLL, 16'hF000, 8'h00, 8'hFF, 4'd2},   // R2
        '{K_RD,   16'hF001, 8'h00, 8'hFF, 4'd2},   // R2
        '{K_WR,   16'hF555, 8'hAA, 8'h00, 4'd3},   // R3 program after erase
        '{K_WR,   16'hFAAA, 8'h55, 8'h00, 4'd3},
        '{K_WR,   16'hF555, 8'hA0, 8'h00, 4'd3},
        '{K_WR,   16'hF000, 8'h3F, 8'h00, 4'd3},
        '{K_POLL, 16'hF000, 8'h00, 8'h3F, 4'd3},   // R3
        '{K_WR,   16'hF555, 8'hAA, 8'h00, 4'd4},   // R4 wrong third byte
        '{K_WR,   16'hFAAA, 8'h55, 8'h00, 4'd4},
        '{K_WR,   16'hF555, 8'h77, 8'h00, 4'd4},
        '{K_WR,   16'hF002, 8'h00, 8'h00, 4'd4},
        '{K_RD,   16'hF002, 8'h00, 8'hFF, 4'd4},   // R4
        '{K_WR,   16'hF555, 8'hAA, 8'h00, 4'd4},   // R4 no resume after mismatch
        '{K_WR,   16'hFAAA, 8'h55, 8'h00, 4'd4},
        '{K_WR,   16'hF555, 8'h99, 8'h00, 4'd4},
        '{K_WR,   16'hF555, 8'hA0, 8'h00, 4'd4},
        '{K_WR,   16'hF003, 8'h00, 8'h00, 4'd4},
        '{K_RD,   16'hF003, 8'h00, 8'hFF, 4'd4},   // R4
        '{K_WR,   16'hF555, 8'hAA, 8'h00, 4'd9},   // R9 aliased program
        '{K_WR,   16'hFAAA, 8'h55, 8'h00, 4'd9},
        '{K_WR,   16'hF555, 8'hA0, 8'h00, 4'd9},
        '{K_WR,   16'hF040, 8'h5A, 8'h00, 4'd9},
        '{K_POLL, 16'hF040, 8'h00, 8'h1A, 4'd9},   // R9
        '{K_RD,   16'hF000, 8'h00, 8'h1A, 4'd9},   // R9
        '{K_RD,   16'h1000, 8'h00, 8'h00, 4'd9},   // R9 outside window
        '{K_CTL,  16'h0000, 8'hC8, 8'h00, 4'd8},   // R8 disarm
        '{K_WR,   16'hF555, 8'hAA, 8'h00, 4'd8},
        '{K_WR,   16'hFAAA, 8'h55, 8'h00, 4'd8},
        '{K_WR,   16'hF555, 8'hA0, 8'h00, 4'd8},
        '{K_WR,   16'hF004, 8'h00, 8'h00, 4'd8},
        '{K_RD,   16'hF004, 8'h00, 8'hFF, 4'd8},   // R8
        '{K_CTL,  16'h0000, 8'h55, 8'h00, 4'd1},   // R1 other value
        '{K_WR,   16'hF555, 8'hAA, 8'h00, 4'd1},
        '{K_WR,   16'hFAAA, 8'h55, 8'h00, 4'd1},
        '{K_WR,   16'hF555, 8'hA0, 8'h00, 4'd1},
        '{K_WR,   16'hF004, 8'h00, 8'h00, 4'd1},
        '{K_RD,   16'hF004, 8'h00, 8'hFF, 4'd1},   // R1
        '{K_CTL,  16'h0000, 8'h38, 8'h00, 4'd1},   // R1 re-arm
        '{K_WR,   16'hF555, 8'hAA, 8'h00, 4'd1},
        '{K_WR,   16'hFAAA, 8'h55, 8'h00, 4'd1},
        '{K_WR,   16'hF555, 8'hA0, 8'h00, 4'd1},
        '{K_WR,   16'hF004, 8'h00, 8'h00, 4'd1},
        '{K_POLL, 16'hF004, 8'h00, 8'h00, 4'd1}    // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC)
    ) i_flash_cmd_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic ctl_wr(input logic [7:0] d);
        ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic bwr(input logic [15:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic brd(input logic [15:0] a, output logic [7:0] v);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic poll(input logic [15:0] a, output logic [7:0] v);
        logic [7:0] p, c;
        brd(a, p);
        c = p;
        for (int i = 0; i < 400; i++) begin
            brd(a, c);
            if (c == p) break;
            p = c;
        end
        v = c;
    endtask

    task automatic prog(input logic [15:0] a, input logic [7:0] d);
        bwr(16'hF555, 8'hAA);
        bwr(16'hFAAA, 8'h55);
        bwr(16'hF555, 8'hA0);
        bwr(a, d);
    endtask

    task automatic erase_all();
        bwr(16'hF555, 8'hAA);
        bwr(16'hFAAA, 8'h55);
        bwr(16'hF555, 8'h80);
        bwr(16'hF555, 8'hAA);
        bwr(16'hFAAA, 8'h55);
        bwr(16'hF555, 8'h10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state of read register and array
        check(bus_rdata == 8'h00, "R9 reset read data", bus_rdata, 8'h00);
        brd(16'hF000, v);
        check(v == 8'hFF, "R9 reset array", v, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].kind)
                K_CTL: ctl_wr(VECS[i].data);
                K_WR:  bwr(VECS[i].addr, VECS[i].data);
                K_RD: begin
                    brd(VECS[i].addr, v);
                    check(v == VECS[i].expv, $sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].expv);
                end
                default: begin
                    poll(VECS[i].addr, v);
                    check(v == VECS[i].expv, $sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].expv);
                end
            endcase
        end

        // R5 and R7: program busy window, read on every cycle
        prog(16'hF010, 8'h0F);
        prev = 8'h00;
        for (int k = 1; k <= PROG_CYC; k++) begin
            brd(16'hF010, v);
            check((v & 8'hBF) == 8'h00, "R5 busy status pattern", v, v & 8'h40);
            if (k > 1) check(v != prev, "R5 status bit flips", v, prev ^ 8'h40);
            prev = v;
        end
        brd(16'hF010, v);
        check(v == 8'h0F, "R7 program busy length", v, 8'h0F);

        // R6 and R7: erase, then a full program sequence while busy
        erase_all();
        prog(16'hF011, 8'h00);
        for (int k = 5; k <= ERASE_CYC; k++) begin
            brd(16'hF011, v);
            check((v & 8'hBF) == 8'h00, "R7 erase still busy", v, v & 8'h40);
        end
        brd(16'hF011, v);
        check(v == 8'hFF, "R6 R7 busy writes ignored and erase length", v, 8'hFF);
        brd(16'hF010, v);
        check(v == 8'hFF, "R2 erase cleared programmed cell", v, 8'hFF);

        // R1: reset disarms command execution
        prog(16'hF012, 8'h00);
        poll(16'hF012, v);
        check(v == 8'h00, "R3 program before reset", v, 8'h00);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(bus_rdata == 8'h00, "R9 read data after reset", bus_rdata, 8'h00);
        prog(16'hF000, 8'h00);
        brd(16'hF000, v);
        check(v == 8'hFF, "R1 disarmed after reset", v, 8'hFF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule